// File: doc/BRIEF.md
# Redundant Life Cycle State Register Codec

This block sits between a life cycle controller's internal status and its software-visible registers. It takes a decoded 5-bit life cycle state, a 5-bit transition count with a validity flag, a post-transition flag, a 2-bit identity state and a vendor test control word. It produces redundant register images: the state code copied into every 5-bit slice of a 30-bit field, a count that saturates to all ones when it cannot be trusted, an identity word with a repeated nibble, and the vendor test word gated by the current state. All of these views are combinational.

In the other direction it decodes the 32-bit transition-target word that software writes. The word is accepted only when its six slices agree, the code names a real destination state, and the two top bits are clear. The result is registered and updates one clock after the write strobe.

Top module: `lcc_csr_codec`

## Requirements
- R1: `state_word_o` holds the effective state code in each of the six 5-bit slices of bits 29:0, with slice 0 in bits 4:0, and bits 31:30 are zero. Codes: RAW=0, TEST_UNLOCKEDn=2n+1 (n=0..7), TEST_LOCKEDn=2n+2 (n=0..6), DEV=16, PROD=17, PROD_END=18, RMA=19, SCRAP=20.
- R2: The temporary codes 21 (post-transition), 22 (escalate) and 23 (invalid) pass through to `state_word_o` unchanged. A `state_i` above 23 is reported as 23.
- R3: When `count_ok_i` is 1, `count_i` equals 24 and `state_i` is 20 or less, the effective state is SCRAP (20).
- R4: `count_o` equals `count_i` when `count_ok_i` is 1, `post_xfer_i` is 0 and `count_i` is 24 or less. In every other case it is 31.
- R5: `id_word_o` has the identity code in each 4-bit nibble. Input 0 gives 0x00000000, 1 gives 0x11111111, and 2 or 3 give 0x22222222.
- R6: `vtest_o` equals `vtest_i` when the effective state is RAW, a TEST code (1..15) or RMA (19). Otherwise it is zero.
- R7: A target write (`tgt_wr_i`=1) is valid when all six slices of `tgt_word_i` are equal, the slice value is 20 or less, and bits 31:30 are 0. One clock later, `tgt_ok_o` is 1 and `tgt_state_o` carries the slice value.
- R8: An invalid target write makes `tgt_ok_o` 0 and `tgt_state_o` 0 one clock later.
- R9: Without a write strobe, `tgt_ok_o` and `tgt_state_o` keep their values.
- R10: During reset, `tgt_ok_o` and `tgt_state_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| state_i | input | 5 | Decoded life cycle state code |
| count_i | input | 5 | Decoded transition count |
| count_ok_i | input | 1 | Transition count decoded correctly |
| post_xfer_i | input | 1 | Controller is in the post-transition phase |
| id_i | input | 2 | Identity state code |
| vtest_i | input | 32 | Vendor test control word |
| tgt_wr_i | input | 1 | Target word write strobe |
| tgt_word_i | input | 32 | Software-written target word |
| state_word_o | output | 32 | Replicated state register image |
| count_o | output | 5 | Count register image |
| id_word_o | output | 32 | Replicated identity register image |
| vtest_o | output | 32 | Gated vendor test control |
| tgt_state_o | output | 5 | Decoded target state |
| tgt_ok_o | output | 1 | Last target write was consistent |

## Verification
The hardest cases to reach are target words that are wrong in only one place. These include a word with a single disagreeing slice, a word whose slices agree on a temporary code, and a word that is otherwise correct but has bit 31 set. The stimulus writes each of these right after a valid target, so a missed rejection shows up as a stale accept. The saturation at a count of 24 is also driven with a gated state (PROD) and an ungated state (RMA). This shows that both the state image and the vendor gate follow the overridden state.

// File: rtl/lcc_pkg.sv
`timescale 1ns/1ps
// Shared widths and state codes for the life cycle register codec.
package lcc_pkg;
    localparam int CODE_W     = 5;
    localparam int NUM_SLICES = 6;
    localparam int REG_W      = 32;
    localparam int ID_W       = 2;
    localparam int NIB_W      = 4;

    localparam logic [CODE_W-1:0] ST_RAW       = 5'd0;
    localparam logic [CODE_W-1:0] ST_TEST_LAST = 5'd15;
    localparam logic [CODE_W-1:0] ST_RMA       = 5'd19;
    localparam logic [CODE_W-1:0] ST_SCRAP     = 5'd20;
    localparam logic [CODE_W-1:0] ST_INVALID   = 5'd23;
    localparam logic [CODE_W-1:0] CNT_LIMIT    = 5'd24;
endpackage

// File: rtl/lcc_status_view.sv
`timescale 1ns/1ps
// Builds the effective state and the replicated state and count images.
// Assumes the input codes are already decoded; only saturation rules apply here.
module lcc_status_view
    import lcc_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NS = NUM_SLICES,
    parameter int RW = REG_W
) (
    input  logic [CW-1:0] state_i,
    input  logic [CW-1:0] count_i,
    input  logic          count_ok_i,
    input  logic          post_i,
    output logic [CW-1:0] eff_state_o,
    output logic [RW-1:0] state_word_o,
    output logic [CW-1:0] count_o
);
    localparam int FILL_W = NS * CW;

    logic cnt_trusted;

    // Choose the state reported to software after the invalid and limit overrides.
    always_comb begin
        cnt_trusted = count_ok_i && (count_i <= CW'(CNT_LIMIT));
        if (state_i > CW'(ST_INVALID))
            eff_state_o = CW'(ST_INVALID);
        else if (count_ok_i && count_i == CW'(CNT_LIMIT) && state_i <= CW'(ST_SCRAP))
            eff_state_o = CW'(ST_SCRAP);
        else
            eff_state_o = state_i;
    end

    // Copy the effective code into every slice of the register.
    for (genvar s = 0; s < NS; s++) begin : g_slice
        assign state_word_o[s*CW +: CW] = eff_state_o;
    end
    if (RW > FILL_W) begin : g_pad
        assign state_word_o[RW-1:FILL_W] = '0;
    end

    // Saturate the count to all ones when it is untrusted or mid-transition.
    always_comb begin
        count_o = (cnt_trusted && !post_i) ? count_i : '1;
    end
endmodule

// File: rtl/lcc_vtest_gate.sv
`timescale 1ns/1ps
// Gates the vendor test word by state: open in raw, test and return states.
// Assumes eff_state_i has already been through the status overrides.
module lcc_vtest_gate
    import lcc_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int RW = REG_W
) (
    input  logic [CW-1:0] eff_state_i,
    input  logic [RW-1:0] vtest_i,
    output logic [RW-1:0] vtest_o
);
    logic open_st;

    // Decide whether the current state allows vendor test control.
    always_comb begin
        open_st = (eff_state_i <= CW'(ST_TEST_LAST)) || (eff_state_i == CW'(ST_RMA));
        vtest_o = open_st ? vtest_i : '0;
    end
endmodule

// File: rtl/lcc_id_view.sv
`timescale 1ns/1ps
// Expands the 2-bit identity code into a word of repeated nibbles.
// Codes 2 and 3 both map to the invalid pattern.
module lcc_id_view
    import lcc_pkg::*;
#(
    parameter int IW = ID_W,
    parameter int NW = NIB_W,
    parameter int RW = REG_W
) (
    input  logic [IW-1:0] id_i,
    output logic [RW-1:0] id_word_o
);
    localparam int NUM_NIB = RW / NW;

    logic [NW-1:0] nib;

    // Map the identity code to its nibble value.
    always_comb begin
        case (id_i)
            2'd0:    nib = NW'(0);
            2'd1:    nib = NW'(1);
            default: nib = NW'(2);
        endcase
    end

    for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
        assign id_word_o[n*NW +: NW] = nib;
    end
endmodule

// File: rtl/lcc_target_dec.sv
`timescale 1ns/1ps
// Checks a software target word for slice agreement and range, then registers it.
// Assumes one write strobe per cycle; with no strobe the outputs hold.
module lcc_target_dec
    import lcc_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NS = NUM_SLICES,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [RW-1:0] word_i,
    output logic [CW-1:0] state_o,
    output logic          ok_o
);
    localparam int FILL_W = NS * CW;

    logic [CW-1:0] base;
    logic          agree;
    logic          word_ok;

    // Compare every slice against slice 0 and check range and padding.
    always_comb begin
        base  = word_i[CW-1:0];
        agree = 1'b1;
        for (int s = 1; s < NS; s++) begin
            if (word_i[s*CW +: CW] != base) agree = 1'b0;
        end
        word_ok = agree && (base <= CW'(ST_SCRAP));
        if (RW > FILL_W) begin
            if (word_i[RW-1:FILL_W] != '0) word_ok = 1'b0;
        end
    end

    // Register the decode result on each write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= '0;
            ok_o    <= 1'b0;
        end else if (wr_i) begin
            state_o <= word_ok ? base : '0;
            ok_o    <= word_ok;
        end
    end
endmodule

// File: rtl/lcc_csr_codec.sv
`timescale 1ns/1ps
// Top of the redundant life cycle register codec: combinational status views
// plus a registered target decoder. Assumes the inputs are already synchronous.
module lcc_csr_codec
    import lcc_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NS = NUM_SLICES,
    parameter int RW = REG_W,
    parameter int IW = ID_W,
    parameter int NW = NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] state_i,
    input  logic [CW-1:0] count_i,
    input  logic          count_ok_i,
    input  logic          post_xfer_i,
    input  logic [IW-1:0] id_i,
    input  logic [RW-1:0] vtest_i,
    input  logic          tgt_wr_i,
    input  logic [RW-1:0] tgt_word_i,
    output logic [RW-1:0] state_word_o,
    output logic [CW-1:0] count_o,
    output logic [RW-1:0] id_word_o,
    output logic [RW-1:0] vtest_o,
    output logic [CW-1:0] tgt_state_o,
    output logic          tgt_ok_o
);
    logic [CW-1:0] eff_state;

    lcc_status_view #(.CW(CW), .NS(NS), .RW(RW)) u_status (
        .state_i      (state_i),
        .count_i      (count_i),
        .count_ok_i   (count_ok_i),
        .post_i       (post_xfer_i),
        .eff_state_o  (eff_state),
        .state_word_o (state_word_o),
        .count_o      (count_o)
    );

    lcc_vtest_gate #(.CW(CW), .RW(RW)) u_gate (
        .eff_state_i (eff_state),
        .vtest_i     (vtest_i),
        .vtest_o     (vtest_o)
    );

    lcc_id_view #(.IW(IW), .NW(NW), .RW(RW)) u_id (
        .id_i      (id_i),
        .id_word_o (id_word_o)
    );

    lcc_target_dec #(.CW(CW), .NS(NS), .RW(RW)) u_tgt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (tgt_wr_i),
        .word_i  (tgt_word_i),
        .state_o (tgt_state_o),
        .ok_o    (tgt_ok_o)
    );
endmodule

// File: rtl/lcc_csr_codec_chk.sv
`timescale 1ns/1ps
// Property checker for the codec, attached to the top through bind.
module lcc_csr_codec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  state_i,
    input logic [4:0]  count_i,
    input logic        count_ok_i,
    input logic        post_xfer_i,
    input logic [31:0] vtest_i,
    input logic        tgt_wr_i,
    input logic [31:0] tgt_word_i,
    input logic [31:0] state_word_o,
    input logic [4:0]  count_o,
    input logic [31:0] id_word_o,
    input logic [31:0] vtest_o,
    input logic [4:0]  tgt_state_o,
    input logic        tgt_ok_o
);
    // R1: top and bottom slices agree and padding is clear
    p_slices_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_word_o[29:25] == state_word_o[4:0] && state_word_o[31:30] == 2'b00);

    // R3: the count limit forces SCRAP
    p_limit_scrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_ok_i && count_i == 5'd24 && state_i <= 5'd20) |-> state_word_o[4:0] == 5'd20);

    // R4: an untrusted or post-transition count saturates
    p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_ok_i || post_xfer_i) |-> count_o == 5'd31);

    // R5: identity nibbles agree
    p_id_rep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        id_word_o[31:28] == id_word_o[3:0]);

    // R6: the gated word is either zero or the input word
    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vtest_o == 32'd0 || vtest_o == vtest_i);

    // R7: a clean replicated word is accepted one cycle later
    p_tgt_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr_i && tgt_word_i == {2'b00, {6{tgt_word_i[4:0]}}} && tgt_word_i[4:0] <= 5'd20)
        |=> (tgt_ok_o && tgt_state_o == $past(tgt_word_i[4:0])));

    // R8: a set padding bit is rejected
    p_tgt_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr_i && tgt_word_i[31:30] != 2'b00) |=> (!tgt_ok_o && tgt_state_o == 5'd0));

    // R9: target outputs hold without a strobe
    p_tgt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_wr_i |=> ($stable(tgt_ok_o) && $stable(tgt_state_o)));
endmodule

bind lcc_csr_codec lcc_csr_codec_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_i      (state_i),
    .count_i      (count_i),
    .count_ok_i   (count_ok_i),
    .post_xfer_i  (post_xfer_i),
    .vtest_i      (vtest_i),
    .tgt_wr_i     (tgt_wr_i),
    .tgt_word_i   (tgt_word_i),
    .state_word_o (state_word_o),
    .count_o      (count_o),
    .id_word_o    (id_word_o),
    .vtest_o      (vtest_o),
    .tgt_state_o  (tgt_state_o),
    .tgt_ok_o     (tgt_ok_o)
);

// File: tb/tb_lcc_csr_codec.sv
`timescale 1ns/1ps
module tb_lcc_csr_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  state_i = '0;
    logic [4:0]  count_i = '0;
    logic        count_ok_i = 1'b0;
    logic        post_xfer_i = 1'b0;
    logic [1:0]  id_i = '0;
    logic [31:0] vtest_i = '0;
    logic        tgt_wr_i = 1'b0;
    logic [31:0] tgt_word_i = '0;
    logic [31:0] state_word_o;
    logic [4:0]  count_o;
    logic [31:0] id_word_o;
    logic [31:0] vtest_o;
    logic [4:0]  tgt_state_o;
    logic        tgt_ok_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] sw;
        logic [4:0]  cnt;
        logic [31:0] idw;
        logic [31:0] vt;
        logic [4:0]  ts;
        logic        tok;
        string       tag;
    } exp_t;

    exp_t q[$];
    logic [4:0] m_ts = '0;
    logic       m_tok = 1'b0;

    always #4 clk = ~clk;

    lcc_csr_codec dut (
        .clk(clk), .rst_n(rst_n), .state_i(state_i), .count_i(count_i),
        .count_ok_i(count_ok_i), .post_xfer_i(post_xfer_i), .id_i(id_i),
        .vtest_i(vtest_i), .tgt_wr_i(tgt_wr_i), .tgt_word_i(tgt_word_i),
        .state_word_o(state_word_o), .count_o(count_o), .id_word_o(id_word_o),
        .vtest_o(vtest_o), .tgt_state_o(tgt_state_o), .tgt_ok_o(tgt_ok_o)
    );

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus and push the values the requirements predict.
    task automatic drive(string tag, logic [4:0] st, logic [4:0] cn, logic cok, logic pst,
                         logic [1:0] id, logic [31:0] vt, logic wr, logic [31:0] tw);
        exp_t e;
        logic [4:0] eff;
        logic [3:0] nib;
        logic       same;
        @(negedge clk);
        state_i = st; count_i = cn; count_ok_i = cok; post_xfer_i = pst;
        id_i = id; vtest_i = vt; tgt_wr_i = wr; tgt_word_i = tw;
        if (st > 5'd23) eff = 5'd23;
        else if (cok && cn == 5'd24 && st <= 5'd20) eff = 5'd20;
        else eff = st;
        e.sw = 32'd0;
        for (int k = 0; k < 6; k++) e.sw = e.sw | (32'(eff) << (5 * k));
        e.cnt = (cok && !pst && cn <= 5'd24) ? cn : 5'd31;
        nib = (id == 2'd0) ? 4'h0 : (id == 2'd1) ? 4'h1 : 4'h2;
        e.idw = {8{nib}};
        e.vt = (eff <= 5'd15 || eff == 5'd19) ? vt : 32'd0;
        if (wr) begin
            same = 1'b1;
            for (int k = 1; k < 6; k++) if (tw[5*k +: 5] != tw[4:0]) same = 1'b0;
            m_tok = same && tw[4:0] <= 5'd20 && tw[31:30] == 2'b00;
            m_ts  = m_tok ? tw[4:0] : 5'd0;
        end
        e.ts = m_ts; e.tok = m_tok; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare each expected item shortly after the edge that follows its drive.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " state_word"}, state_word_o, e.sw);
                check({e.tag, " count"}, 32'(count_o), 32'(e.cnt));
                check({e.tag, " id_word"}, id_word_o, e.idw);
                check({e.tag, " vtest"}, vtest_o, e.vt);
                check({e.tag, " tgt_state"}, 32'(tgt_state_o), 32'(e.ts));
                check({e.tag, " tgt_ok"}, 32'(tgt_ok_o), 32'(e.tok));
            end
        end
    end

    function automatic logic [31:0] rep(logic [4:0] v);
        return {2'b00, {6{v}}};
    endfunction

    initial begin
        #800000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tgt_wr_i = 1'b1;
        tgt_word_i = rep(5'd5);
        repeat (3) @(posedge clk);
        #2;
        check("R10 reset tgt_ok", 32'(tgt_ok_o), 32'd0);
        check("R10 reset tgt_state", 32'(tgt_state_o), 32'd0);
        @(negedge clk);
        tgt_wr_i = 1'b0;
        rst_n = 1'b1;
        // R1, R6: stable states with trusted count
        drive("R1 raw",      5'd0,  5'd1, 1, 0, 2'd0, 32'hA5A5_0001, 0, 0);
        drive("R1 tu0",      5'd1,  5'd2, 1, 0, 2'd1, 32'h1234_5678, 0, 0);
        drive("R1 tl0",      5'd2,  5'd3, 1, 0, 2'd1, 32'h0F0F_0F0F, 0, 0);
        drive("R6 tu7",      5'd15, 5'd9, 1, 0, 2'd1, 32'hDEAD_BEEF, 0, 0);
        drive("R6 dev",      5'd16, 5'd9, 1, 0, 2'd1, 32'hDEAD_BEEF, 0, 0);
        drive("R6 prod",     5'd17, 5'd9, 1, 0, 2'd1, 32'hFFFF_FFFF, 0, 0);
        drive("R6 prod_end", 5'd18, 5'd9, 1, 0, 2'd1, 32'hFFFF_FFFF, 0, 0);
        drive("R6 rma",      5'd19, 5'd9, 1, 0, 2'd1, 32'h8000_0001, 0, 0);
        drive("R1 scrap",    5'd20, 5'd9, 1, 0, 2'd1, 32'h8000_0001, 0, 0);
        // R2: temporary and out-of-range codes
        drive("R2 post",     5'd21, 5'd9, 1, 1, 2'd1, 32'h1, 0, 0);
        drive("R2 esc",      5'd22, 5'd9, 1, 0, 2'd1, 32'h1, 0, 0);
        drive("R2 invalid",  5'd23, 5'd9, 1, 0, 2'd1, 32'h1, 0, 0);
        drive("R2 high",     5'd29, 5'd9, 1, 0, 2'd1, 32'h1, 0, 0);
        // R3: count limit forces scrap, also gating vendor test
        drive("R3 lim prod", 5'd17, 5'd24, 1, 0, 2'd1, 32'h77, 0, 0);
        drive("R3 lim rma",  5'd19, 5'd24, 1, 0, 2'd1, 32'h77, 0, 0);
        drive("R3 lim bad",  5'd19, 5'd24, 0, 0, 2'd1, 32'h77, 0, 0);
        // R4: count saturation
        drive("R4 cnt ok23", 5'd16, 5'd23, 1, 0, 2'd0, 32'h0, 0, 0);
        drive("R4 cnt bad",  5'd16, 5'd4,  0, 0, 2'd0, 32'h0, 0, 0);
        drive("R4 cnt post", 5'd16, 5'd4,  1, 1, 2'd0, 32'h0, 0, 0);
        drive("R4 cnt 25",   5'd16, 5'd25, 1, 0, 2'd0, 32'h0, 0, 0);
        // R5: identity codes
        drive("R5 id0", 5'd16, 5'd1, 1, 0, 2'd0, 32'h0, 0, 0);
        drive("R5 id1", 5'd16, 5'd1, 1, 0, 2'd1, 32'h0, 0, 0);
        drive("R5 id2", 5'd16, 5'd1, 1, 0, 2'd2, 32'h0, 0, 0);
        drive("R5 id3", 5'd16, 5'd1, 1, 0, 2'd3, 32'h0, 0, 0);
        // R7, R8, R9: target decode
        drive("R7 tgt dev",   5'd0, 5'd1, 1, 0, 2'd0, 32'h0, 1, rep(5'd16));
        drive("R9 hold",      5'd0, 5'd1, 1, 0, 2'd0, 32'h0, 0, rep(5'd3));
        drive("R8 tgt 21",    5'd0, 5'd1, 1, 0, 2'd0, 32'h0, 1, rep(5'd21));
        drive("R7 tgt 20",    5'd0, 5'd1, 1, 0, 2'd0, 32'h0, 1, rep(5'd20));
        drive("R8 one slice", 5'd0, 5'd1, 1, 0, 2'd0, 32'h0, 1, rep(5'd17) ^ (32'd1 << 20));
        drive("R7 tgt 0",     5'd0, 5'd1, 1, 0, 2'd0, 32'h0, 1, rep(5'd0));
        drive("R7 tgt 17",    5'd0, 5'd1, 1, 0, 2'd0, 32'h0, 1, rep(5'd17));
        drive("R8 pad bit",   5'd0, 5'd1, 1, 0, 2'd0, 32'h0, 1, rep(5'd17) | 32'h8000_0000);
        drive("R7 tgt 19",    5'd0, 5'd1, 1, 0, 2'd0, 32'h0, 1, rep(5'd19));
        drive("R9 hold2",     5'd0, 5'd1, 1, 0, 2'd0, 32'h0, 0, 32'hFFFF_FFFF);
        drive("R9 hold3",     5'd0, 5'd1, 1, 0, 2'd0, 32'h0, 0, 32'h0);
        @(negedge clk);
        tgt_wr_i = 1'b0;
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule